// File: doc/BRIEF.md
# Banked UART Enhanced Register Window

This block is the register-access front end of a 16550-style UART with eight byte-wide register offsets. It owns the line control register and a small set of extended registers. Any access it does not claim goes to the standard UART core over a forwarding strobe pair, and read data for those accesses comes back from the core.

When the line control register holds a magic byte (0xBF by default), offset 2 stops reaching the core's FIFO control and interrupt identification register and reaches a local feature register instead. Offsets 4 to 7 then expose one of four register banks, selected by a field of that feature register. The banks hold the software flow-control characters, the FIFO threshold levels, an enumeration byte and a read-only device identifier.

A feature-register enable bit outlives the magic view. While it is set, offset 7 reads a good-data length supplied by the receive path, even in the standard view. Stored values are driven on output ports for the rest of the UART.

Top module: `uart_bank_window`

## Requirements
- R1: After reset, the line control register, the feature register, every writable bank register and `rdata` are all zero.
- R2: Offset 3 is always the local line control register. It reads back what was last written, and accesses to it never raise `std_wr` or `std_rd`.
- R3: When `lcr_val` equals the magic byte, offset 2 reads and writes the local feature register without forwarding. Otherwise offset 2 is forwarded to the core.
- R4: Feature register bits 7:6 select the bank seen at offsets 4 to 7 in the magic view: 0x00 is bank 0, 0x40 is bank 1, 0x80 is bank 2 and 0xC0 is bank 3. Writing through one bank leaves the others unchanged.
- R5: Bank 0 offsets 4, 5, 6 and 7 hold the first on character, the second on character, the first off character and the second off character. They drive `xon1`, `xon2`, `xoff1` and `xoff2`.
- R6: Bank 1 offsets 4, 5, 6 and 7 hold the receive low level, receive high level, receive trigger level and transmit low level. They drive `rx_low`, `rx_high`, `rx_trig` and `tx_low`.
- R7: Bank 2 offset 4 is a read/write enumeration byte on `enum_val`. Offset 5 always reads the `HW_ID` parameter (default 0x01), and writes to it are ignored. Offsets 6 and 7 read zero.
- R8: Bank 3 offsets 4 to 7 read zero, and writes to them change no register.
- R9: Feature register bit 4 (0x10) is the enhanced enable, and it keeps its value when the line control register leaves the magic byte. In the standard view with that bit set, a read of offset 7 returns `{gd_bad, gd_len}`, while a write to offset 7 is forwarded. With the bit clear, offset 7 reads are forwarded.
- R10: In the standard view, offsets 0, 1, 2 and 4 to 7 are forwarded. `std_wr`/`std_rd` follow `wr_en`/`rd_en` combinationally in the same cycle, and the read returns `std_rdata` as sampled in that cycle.
- R11: `rdata` loads on the clock edge that samples `rd_en` high and holds its value in every cycle without a read.
- R12: Offsets 0 and 1 are forwarded in the magic view as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| std_wr | output | 1 | Write forwarded to the standard core |
| std_rd | output | 1 | Read forwarded to the standard core |
| std_rdata | input | 8 | Read data from the standard core |
| gd_len | input | 7 | Good-data byte count from the receive path |
| gd_bad | input | 1 | Bad data present in the receive FIFO |
| lcr_val | output | 8 | Line control register |
| efr_val | output | 8 | Feature register |
| xon1 | output | 8 | First on character |
| xon2 | output | 8 | Second on character |
| xoff1 | output | 8 | First off character |
| xoff2 | output | 8 | Second off character |
| rx_low | output | 8 | Receive low level |
| rx_high | output | 8 | Receive high level |
| rx_trig | output | 8 | Receive trigger level |
| tx_low | output | 8 | Transmit low level |
| enum_val | output | 8 | Enumeration byte |

## Verification
The hardest state to reach is the one where the enhanced enable is set but the line control register no longer holds the magic byte. Offset 7 then splits: reads are local and writes are forwarded. Getting there takes a full sequence through the ports: open the magic view, write the feature register with bit 4 set, then restore an ordinary line control value. After that, one read and one write of offset 7 are issued. A second pass clears the enable through the magic view and confirms that offset 7 reads are forwarded again. Bank isolation is checked by filling banks 0 and 1, writing all-ones through bank 3, and reading both filled banks back.

// File: rtl/uart_win_pkg.sv
package uart_win_pkg;
   localparam int REG_W  = 8;
   localparam int ADDR_W = 3;
   localparam int SLOT_N = 4;
   localparam int BANK_N = 4;
   localparam int GDL_W  = REG_W - 1;
   localparam int SEL_W  = $clog2(BANK_N) + $clog2(SLOT_N);

   localparam logic [ADDR_W-1:0] OFS_EFR = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_LCR = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_GDL = 3'd7;
   localparam int EFR_EN_BIT = 4;
   localparam int BANK_LSB   = 6;

   typedef enum logic [2:0] {
      TGT_STD, TGT_LCR, TGT_EFR, TGT_BANK, TGT_GDL
   } tgt_e;

   typedef enum logic [1:0] {SK_RW, SK_ID, SK_ZERO} slot_kind_e;

   function automatic slot_kind_e slot_kind(input int b, input int s);
      if (b <= 1)           return SK_RW;
      if (b == 2 && s == 0) return SK_RW;
      if (b == 2 && s == 1) return SK_ID;
      return SK_ZERO;
   endfunction
endpackage

// File: rtl/uart_win_decode.sv
module uart_win_decode
   import uart_win_pkg::*;
#(
   parameter logic [REG_W-1:0] MAGIC = 8'hBF
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  lcr,
   input  logic              efr_en,
   output tgt_e              rd_tgt,
   output tgt_e              wr_tgt
);
   logic enh_view;
   logic gdl_on;

   always_comb begin
      enh_view = (lcr == MAGIC);
      gdl_on   = !enh_view && efr_en && (addr == OFS_GDL);
      if (addr == OFS_LCR)                  rd_tgt = TGT_LCR;
      else if (enh_view && addr == OFS_EFR) rd_tgt = TGT_EFR;
      else if (enh_view && addr[2])         rd_tgt = TGT_BANK;
      else if (gdl_on)                      rd_tgt = TGT_GDL;
      else                                  rd_tgt = TGT_STD;
      wr_tgt = (rd_tgt == TGT_GDL) ? TGT_STD : rd_tgt;
   end
endmodule

// File: rtl/uart_win_banks.sv
module uart_win_banks
   import uart_win_pkg::*;
#(
   parameter logic [REG_W-1:0] HW_ID = 8'h01
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  logic [$clog2(BANK_N)-1:0]         bank,
   input  logic [$clog2(SLOT_N)-1:0]         slot,
   input  logic [REG_W-1:0]                  wdata,
   output logic [BANK_N*SLOT_N*REG_W-1:0]    regs_flat,
   output logic [REG_W-1:0]                  rd_byte
);
   for (genvar b = 0; b < BANK_N; b++) begin : g_bank
      for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
         localparam slot_kind_e KIND = slot_kind(b, s);
         localparam int IDX = b * SLOT_N + s;
         if (KIND == SK_RW) begin : g_rw
            logic [REG_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (wr && bank == b[$clog2(BANK_N)-1:0] && slot == s[$clog2(SLOT_N)-1:0])
                  q <= wdata;
            end
            assign regs_flat[IDX*REG_W +: REG_W] = q;
         end else if (KIND == SK_ID) begin : g_id
            assign regs_flat[IDX*REG_W +: REG_W] = HW_ID;
         end else begin : g_zero
            assign regs_flat[IDX*REG_W +: REG_W] = '0;
         end
      end
   end

   logic [SEL_W-1:0] sel;
   assign sel     = {bank, slot};
   assign rd_byte = regs_flat[sel*REG_W +: REG_W];
endmodule

// File: rtl/uart_win_rdmux.sv
module uart_win_rdmux
   import uart_win_pkg::*;
(
   input  tgt_e             tgt,
   input  logic [REG_W-1:0] lcr,
   input  logic [REG_W-1:0] efr,
   input  logic [REG_W-1:0] bank_byte,
   input  logic [GDL_W-1:0] gd_len,
   input  logic             gd_bad,
   input  logic [REG_W-1:0] std_rdata,
   output logic [REG_W-1:0] rd_byte
);
   always_comb begin
      unique case (tgt)
         TGT_LCR:  rd_byte = lcr;
         TGT_EFR:  rd_byte = efr;
         TGT_BANK: rd_byte = bank_byte;
         TGT_GDL:  rd_byte = {gd_bad, gd_len};
         default:  rd_byte = std_rdata;
      endcase
   end
endmodule

// File: rtl/uart_bank_window.sv
module uart_bank_window
   import uart_win_pkg::*;
#(
   parameter logic [REG_W-1:0] MAGIC = 8'hBF,
   parameter logic [REG_W-1:0] HW_ID = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              std_wr,
   output logic              std_rd,
   input  logic [7:0]        std_rdata,
   input  logic [6:0]        gd_len,
   input  logic              gd_bad,
   output logic [7:0]        lcr_val,
   output logic [7:0]        efr_val,
   output logic [7:0]        xon1,
   output logic [7:0]        xon2,
   output logic [7:0]        xoff1,
   output logic [7:0]        xoff2,
   output logic [7:0]        rx_low,
   output logic [7:0]        rx_high,
   output logic [7:0]        rx_trig,
   output logic [7:0]        tx_low,
   output logic [7:0]        enum_val
);
   if (HW_ID == '0) begin : g_chk_id
      $error("HW_ID must be nonzero");
   end
   if (MAGIC == '0) begin : g_chk_magic
      $error("MAGIC must differ from the reset value of the line control register");
   end

   localparam int BANK_W = $clog2(BANK_N);
   localparam int SLOT_W = $clog2(SLOT_N);

   tgt_e rd_tgt, wr_tgt;
   logic [REG_W-1:0] lcr_q, efr_q, bank_byte, rd_next;
   logic [BANK_N*SLOT_N*REG_W-1:0] regs_flat;

   uart_win_decode #(.MAGIC(MAGIC)) i_decode (
      .addr   (addr),
      .lcr    (lcr_q),
      .efr_en (efr_q[EFR_EN_BIT]),
      .rd_tgt (rd_tgt),
      .wr_tgt (wr_tgt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q <= '0;
         efr_q <= '0;
      end else if (wr_en) begin
         if (wr_tgt == TGT_LCR) lcr_q <= wdata;
         if (wr_tgt == TGT_EFR) efr_q <= wdata;
      end
   end

   uart_win_banks #(.HW_ID(HW_ID)) i_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_en && wr_tgt == TGT_BANK),
      .bank      (efr_q[BANK_LSB +: BANK_W]),
      .slot      (addr[SLOT_W-1:0]),
      .wdata     (wdata),
      .regs_flat (regs_flat),
      .rd_byte   (bank_byte)
   );

   uart_win_rdmux i_rdmux (
      .tgt       (rd_tgt),
      .lcr       (lcr_q),
      .efr       (efr_q),
      .bank_byte (bank_byte),
      .gd_len    (gd_len),
      .gd_bad    (gd_bad),
      .std_rdata (std_rdata),
      .rd_byte   (rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

   assign std_wr   = wr_en && (wr_tgt == TGT_STD);
   assign std_rd   = rd_en && (rd_tgt == TGT_STD);
   assign lcr_val  = lcr_q;
   assign efr_val  = efr_q;
   assign xon1     = regs_flat[(0*SLOT_N+0)*REG_W +: REG_W];
   assign xon2     = regs_flat[(0*SLOT_N+1)*REG_W +: REG_W];
   assign xoff1    = regs_flat[(0*SLOT_N+2)*REG_W +: REG_W];
   assign xoff2    = regs_flat[(0*SLOT_N+3)*REG_W +: REG_W];
   assign rx_low   = regs_flat[(1*SLOT_N+0)*REG_W +: REG_W];
   assign rx_high  = regs_flat[(1*SLOT_N+1)*REG_W +: REG_W];
   assign rx_trig  = regs_flat[(1*SLOT_N+2)*REG_W +: REG_W];
   assign tx_low   = regs_flat[(1*SLOT_N+3)*REG_W +: REG_W];
   assign enum_val = regs_flat[(2*SLOT_N+0)*REG_W +: REG_W];
endmodule

// File: rtl/uart_win_chk.sv
module uart_win_chk #(
   parameter logic [7:0] MAGIC = 8'hBF,
   parameter logic [7:0] HW_ID = 8'h01
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] addr,
   input logic       wr_en,
   input logic       rd_en,
   input logic [7:0] wdata,
   input logic [7:0] rdata,
   input logic       std_wr,
   input logic       std_rd,
   input logic [6:0] gd_len,
   input logic       gd_bad,
   input logic [7:0] lcr_val,
   input logic [7:0] efr_val
);
   p_lcr_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && addr == 3'd3) |-> (!std_wr && !std_rd));

   p_lcr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 3'd3) |=> (lcr_val == $past(wdata)));

   p_efr_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && addr == 3'd2 && lcr_val == MAGIC) |-> (!std_wr && !std_rd));

   p_efr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == 3'd2 && lcr_val == MAGIC) |=> $stable(efr_val));

   p_hwid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && lcr_val == MAGIC && efr_val[7:6] == 2'd2 && addr == 3'd5) |=> (rdata == HW_ID));

   p_bank3_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && lcr_val == MAGIC && efr_val[7:6] == 2'd3 && addr[2]) |=> (rdata == 8'h00));

   p_gdl_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && lcr_val != MAGIC && efr_val[4] && addr == 3'd7)
      |=> (rdata == {$past(gd_bad), $past(gd_len)}));

   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

bind uart_bank_window uart_win_chk #(.MAGIC(MAGIC), .HW_ID(HW_ID)) i_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .wdata(wdata), .rdata(rdata), .std_wr(std_wr), .std_rd(std_rd),
   .gd_len(gd_len), .gd_bad(gd_bad), .lcr_val(lcr_val), .efr_val(efr_val)
);

// File: tb/test_uart_bank_window.sv
module test_uart_bank_window;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       std_wr, std_rd;
   logic [7:0] std_rdata;
   logic [6:0] gd_len = 7'h05;
   logic       gd_bad = 1'b1;
   logic [7:0] lcr_val, efr_val, xon1, xon2, xoff1, xoff2;
   logic [7:0] rx_low, rx_high, rx_trig, tx_low, enum_val;

   assign std_rdata = 8'hA0 | {5'b0, addr};

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_bank_window i_uart_bank_window (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .std_wr(std_wr), .std_rd(std_rd),
      .std_rdata(std_rdata), .gd_len(gd_len), .gd_bad(gd_bad),
      .lcr_val(lcr_val), .efr_val(efr_val), .xon1(xon1), .xon2(xon2),
      .xoff1(xoff1), .xoff2(xoff2), .rx_low(rx_low), .rx_high(rx_high),
      .rx_trig(rx_trig), .tx_low(tx_low), .enum_val(enum_val)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       launch = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // driver: write, with expected forwarding
   task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit fwd, input string req);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      #1 chk(std_wr == fwd, req, {7'b0, std_wr}, {7'b0, fwd});
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   // driver: read, pushes expected data into the scoreboard
   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input bit fwd, input string req);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      #1 chk(std_rd == fwd, req, {7'b0, std_rd}, {7'b0, fwd});
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   // monitor
   always @(posedge clk) launch <= rd_en;
   always @(negedge clk) begin
      if (launch && rst_n) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "scoreboard underflow", rdata, 8'h00);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rdata == e, t, rdata, e);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 50000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 00 expected 01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(lcr_val == 0, "R1 lcr", lcr_val, 8'h00);
      chk(efr_val == 0, "R1 efr", efr_val, 8'h00);
      chk(xon1 == 0 && rx_trig == 0 && enum_val == 0, "R1 banks", xon1 | rx_trig | enum_val, 8'h00);
      chk(rdata == 0, "R1 rdata", rdata, 8'h00);

      // R2 line control
      rd(3'd3, 8'h00, 1'b0, "R2 lcr reset read");
      wr(3'd3, 8'h03, 1'b0, "R2 lcr write local");
      rd(3'd3, 8'h03, 1'b0, "R2 lcr readback");

      // R10 / R3 standard view forwarding
      wr(3'd2, 8'hC1, 1'b1, "R3 offset2 forwarded");
      rd(3'd5, 8'hA5, 1'b1, "R10 std read 5");
      rd(3'd2, 8'hA2, 1'b1, "R3 std read 2");
      rd(3'd7, 8'hA7, 1'b1, "R9 offset7 forwarded when disabled");
      wr(3'd6, 8'h44, 1'b1, "R10 std write 6");

      // magic view, bank 0
      wr(3'd3, 8'hBF, 1'b0, "R2 magic write");
      wr(3'd2, 8'h10, 1'b0, "R3 efr write local");
      rd(3'd2, 8'h10, 1'b0, "R3 efr read");
      wr(3'd4, 8'h11, 1'b0, "R5 xon1");
      wr(3'd5, 8'h13, 1'b0, "R5 xon2");
      wr(3'd6, 8'h91, 1'b0, "R5 xoff1");
      wr(3'd7, 8'h93, 1'b0, "R5 xoff2");
      rd(3'd4, 8'h11, 1'b0, "R5 read 4");
      rd(3'd7, 8'h93, 1'b0, "R5 read 7");
      rd(3'd0, 8'hA0, 1'b1, "R12 offset0 forwarded in magic view");
      wr(3'd1, 8'h22, 1'b1, "R12 offset1 write forwarded");
      @(negedge clk);
      chk(xon1 == 8'h11, "R5 xon1 out", xon1, 8'h11);
      chk(xon2 == 8'h13, "R5 xon2 out", xon2, 8'h13);
      chk(xoff1 == 8'h91, "R5 xoff1 out", xoff1, 8'h91);
      chk(xoff2 == 8'h93, "R5 xoff2 out", xoff2, 8'h93);

      // bank 1
      wr(3'd2, 8'h50, 1'b0, "R4 select bank1");
      wr(3'd4, 8'h04, 1'b0, "R6 rx low");
      wr(3'd5, 8'h30, 1'b0, "R6 rx high");
      wr(3'd6, 8'h10, 1'b0, "R6 rx trig");
      wr(3'd7, 8'h08, 1'b0, "R6 tx low");
      rd(3'd5, 8'h30, 1'b0, "R6 read 5");
      rd(3'd4, 8'h04, 1'b0, "R4 bank1 offset4 differs from bank0");
      @(negedge clk);
      chk(rx_low == 8'h04 && rx_high == 8'h30, "R6 rx levels out", rx_high, 8'h30);
      chk(rx_trig == 8'h10 && tx_low == 8'h08, "R6 trig/tx out", rx_trig, 8'h10);
      chk(xon1 == 8'h11, "R4 bank0 untouched", xon1, 8'h11);

      // bank 2
      wr(3'd2, 8'h90, 1'b0, "R4 select bank2");
      wr(3'd4, 8'h5A, 1'b0, "R7 enum write");
      wr(3'd5, 8'hFF, 1'b0, "R7 id write ignored");
      wr(3'd6, 8'h77, 1'b0, "R7 offset6 write");
      rd(3'd4, 8'h5A, 1'b0, "R7 enum read");
      rd(3'd5, 8'h01, 1'b0, "R7 id read");
      rd(3'd6, 8'h00, 1'b0, "R7 offset6 zero");
      rd(3'd7, 8'h00, 1'b0, "R7 offset7 zero");
      @(negedge clk);
      chk(enum_val == 8'h5A, "R7 enum out", enum_val, 8'h5A);

      // bank 3
      wr(3'd2, 8'hD0, 1'b0, "R4 select bank3");
      for (int i = 4; i < 8; i++) wr(3'(i), 8'hFF, 1'b0, "R8 bank3 write");
      for (int i = 4; i < 8; i++) rd(3'(i), 8'h00, 1'b0, "R8 bank3 read zero");
      wr(3'd2, 8'h10, 1'b0, "R4 back to bank0");
      rd(3'd4, 8'h11, 1'b0, "R8 bank0 intact");
      rd(3'd7, 8'h93, 1'b0, "R8 bank0 intact 7");
      wr(3'd2, 8'h50, 1'b0, "R4 back to bank1");
      rd(3'd6, 8'h10, 1'b0, "R8 bank1 intact");
      @(negedge clk);
      chk(enum_val == 8'h5A && tx_low == 8'h08, "R8 outputs intact", enum_val, 8'h5A);

      // enable persists after leaving magic view
      wr(3'd3, 8'h03, 1'b0, "R2 leave magic");
      @(negedge clk);
      chk(efr_val == 8'h50, "R9 efr persists", efr_val, 8'h50);
      rd(3'd7, 8'h85, 1'b0, "R9 gdl read");
      gd_len = 7'h7F; gd_bad = 1'b0;
      rd(3'd7, 8'h7F, 1'b0, "R9 gdl read 2");
      wr(3'd7, 8'h12, 1'b1, "R9 offset7 write forwarded");
      rd(3'd4, 8'hA4, 1'b1, "R10 offset4 std after restore");
      rd(3'd2, 8'hA2, 1'b1, "R3 offset2 std after restore");

      // clear enable
      wr(3'd3, 8'hBF, 1'b0, "R2 magic again");
      wr(3'd2, 8'h00, 1'b0, "R9 clear enable");
      wr(3'd3, 8'h00, 1'b0, "R2 leave magic");
      rd(3'd7, 8'hA7, 1'b1, "R9 offset7 forwarded after clear");

      // R11 hold
      repeat (4) @(negedge clk);
      chk(rdata == 8'hA7, "R11 rdata holds", rdata, 8'hA7);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule